// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the control-state bookkeeping that a processor core needs when a synchronous exception is taken. When the exception request is sampled, the block records where execution stopped and why, marks the core as being at exception level, and moves the register shadow-set selection on to the exception set. It then works out the handler address and sends a fresh program-counter triplet (PC, next PC, next-next PC) to fetch, together with a one-cycle redirect strobe.

The pipeline supplies the current PC, next PC and next-next PC, plus a 5-bit cause code and the vector offset that belongs to the exception. When next PC is not PC+4, the faulting instruction sits in a branch delay slot. In that case the recorded return address is moved back one instruction and the delay-slot flag is set. The handler address comes from a fixed boot-ROM entry while the bootstrap-vector bit is set. Otherwise it is the programmable exception base plus the vector offset. Software can load each held register through a simple one-cycle write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, the boot-vector bit is 1, the exception-level bit is 0, all three shadow-set fields are 0, the redirect strobe is 0, and the PC triplet outputs hold 0xBFC00000, 0xBFC00004 and 0xBFC00008.
- R2: Every exception entry leaves the exception-level bit at 1, whether or not it was already 1.
- R3: On an entry taken while both the exception-level bit and the boot-vector bit are 0, the previous-set field takes the old current-set value and the current-set field takes the exception-set value. The exception-set field is unchanged.
- R4: On an entry taken while either the exception-level bit or the boot-vector bit is 1, all three shadow-set fields keep their values.
- R5: If next PC differs from PC+4, the return address becomes PC−4 and the delay-slot flag becomes 1. Otherwise the return address becomes PC and the delay-slot flag becomes 0.
- R6: Every entry writes the supplied cause code into the cause-code field and clears the 2-bit coprocessor field.
- R7: With the boot-vector bit 0, the handler address is the exception base plus the vector offset (the arithmetic overflow case uses code 0xC and offset 0x180).
- R8: With the boot-vector bit 1, the handler address is 0xBFC00200. The entry sequence never changes the boot-vector bit, and the handler choice uses the value that bit holds when the request is sampled.
- R9: All register updates take effect at the clock edge that samples the request. In the following cycle the redirect strobe is 1 for exactly one cycle, and the outputs carry handler, handler+4 and handler+8. Without a request the strobe is 0 and the triplet outputs hold their values.
- R10: A software write (select 0 = status: data[0] exception level, data[1] boot vector; 1 = shadow: data[3:0] current, [7:4] exception, [11:8] previous; 2 = return address; 3 = cause: data[4:0] code, [5] delay slot, [7:6] coprocessor field; 4 = exception base) updates the selected register at the clock edge. A write in the same cycle as an exception request is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | One-cycle exception request |
| excCode | input | 5 | Cause code of the exception |
| excVecOfs | input | 12 | Vector offset added to the exception base |
| curPc | input | 32 | PC of the faulting instruction |
| nextPc | input | 32 | Next PC in flight |
| nextNextPc | input | 32 | Next-next PC in flight |
| swWrEn | input | 1 | Software write enable |
| swWrSel | input | 3 | Software write register select |
| swWrData | input | 32 | Software write data |
| statusExl | output | 1 | Exception-level bit |
| statusBev | output | 1 | Boot-vector bit |
| shadowCss | output | 4 | Current shadow set |
| shadowEss | output | 4 | Exception shadow set |
| shadowPss | output | 4 | Previous shadow set |
| epc | output | 32 | Exception return address |
| causeCode | output | 5 | Cause code field |
| causeBd | output | 1 | Delay-slot flag |
| causeCe | output | 2 | Coprocessor number field |
| ebase | output | 32 | Exception base register |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| newPc | output | 32 | PC sent to fetch |
| newNextPc | output | 32 | Next PC sent to fetch |
| newNextNextPc | output | 32 | Next-next PC sent to fetch |

## Verification
Entries are driven with straight-line PC triplets and with delay-slot triplets whose next PC is a branch target. This separates the return-address rewind from the plain case. The same entries are repeated under every combination of the exception-level and boot-vector bits, so a swap that fires on only one of the two conditions shows up, and so does a wrong handler-base choice. Random software writes are mixed into the stream, some of them in the same cycle as a request, which checks that writes land in the right fields and that entry wins. Random offsets and bases check the handler adder away from the 0x180 case.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_SHADOW = 3'd1,
    SEL_EPC    = 3'd2,
    SEL_CAUSE  = 3'd3,
    SEL_EBASE  = 3'd4
  } swSel_e;

  typedef struct packed {
    logic takeExc;
    logic swapShadow;
    logic delaySlot;
    logic wrStatus;
    logic wrShadow;
    logic wrEpc;
    logic wrCause;
    logic wrEbase;
  } ctlStrobes_t;

  localparam logic [31:0] RESET_VECTOR = 32'hBFC0_0000;
  localparam logic [31:0] BOOT_HANDLER = 32'hBFC0_0200;

endpackage

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            excReq,
  input  logic            statusExl,
  input  logic            statusBev,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] nextPc,
  input  logic            swWrEn,
  input  logic [2:0]      swWrSel,
  output ctlStrobes_t     strobes
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic swGo;

  always_comb begin
    swGo = swWrEn && !excReq;
    strobes            = '0;
    strobes.takeExc    = excReq;
    strobes.swapShadow = excReq && !statusExl && !statusBev;
    strobes.delaySlot  = (curPc + STEP) != nextPc;
    strobes.wrStatus   = swGo && (swWrSel == SEL_STATUS);
    strobes.wrShadow   = swGo && (swWrSel == SEL_SHADOW);
    strobes.wrEpc      = swGo && (swWrSel == SEL_EPC);
    strobes.wrCause    = swGo && (swWrSel == SEL_CAUSE);
    strobes.wrEbase    = swGo && (swWrSel == SEL_EBASE);
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int INSN_BYTES = 4,
  parameter int SS_W = 4,
  parameter int CODE_W = 5,
  parameter int CE_W = 2,
  parameter int VEC_W = 12,
  parameter logic [XLEN-1:0] EBASE_RST = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [CODE_W-1:0] excCode,
  input  logic [VEC_W-1:0]  excVecOfs,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   swWrData,
  output logic              statusExl,
  output logic              statusBev,
  output logic [SS_W-1:0]   shadowCss,
  output logic [SS_W-1:0]   shadowEss,
  output logic [SS_W-1:0]   shadowPss,
  output logic [XLEN-1:0]   epc,
  output logic [CODE_W-1:0] causeCode,
  output logic              causeBd,
  output logic [CE_W-1:0]   causeCe,
  output logic [XLEN-1:0]   ebase,
  output logic              redirect,
  output logic [XLEN-1:0]   newPc,
  output logic [XLEN-1:0]   newNextPc,
  output logic [XLEN-1:0]   newNextNextPc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam int CAUSE_BD_BIT = CODE_W;
  localparam int CAUSE_CE_LO  = CODE_W + 1;

  logic [XLEN-1:0] handlerAddr;

  always_comb begin
    if (statusBev) handlerAddr = BOOT_HANDLER;
    else           handlerAddr = ebase + XLEN'(excVecOfs);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusExl <= 1'b0;
      statusBev <= 1'b1;
    end else if (strobes.takeExc) begin
      statusExl <= 1'b1;
    end else if (strobes.wrStatus) begin
      statusExl <= swWrData[0];
      statusBev <= swWrData[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCss <= '0;
      shadowEss <= '0;
      shadowPss <= '0;
    end else if (strobes.swapShadow) begin
      shadowPss <= shadowCss;
      shadowCss <= shadowEss;
    end else if (strobes.wrShadow) begin
      shadowCss <= swWrData[SS_W-1:0];
      shadowEss <= swWrData[2*SS_W-1:SS_W];
      shadowPss <= swWrData[3*SS_W-1:2*SS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epc       <= '0;
      causeCode <= '0;
      causeBd   <= 1'b0;
      causeCe   <= '0;
      ebase     <= EBASE_RST;
    end else if (strobes.takeExc) begin
      epc       <= strobes.delaySlot ? (curPc - STEP) : curPc;
      causeBd   <= strobes.delaySlot;
      causeCode <= excCode;
      causeCe   <= '0;
    end else begin
      if (strobes.wrEpc) epc <= swWrData;
      if (strobes.wrCause) begin
        causeCode <= swWrData[CODE_W-1:0];
        causeBd   <= swWrData[CAUSE_BD_BIT];
        causeCe   <= swWrData[CAUSE_CE_LO+CE_W-1:CAUSE_CE_LO];
      end
      if (strobes.wrEbase) ebase <= swWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirect      <= 1'b0;
      newPc         <= RESET_VECTOR;
      newNextPc     <= RESET_VECTOR + STEP;
      newNextNextPc <= RESET_VECTOR + 2 * STEP;
    end else begin
      redirect <= strobes.takeExc;
      if (strobes.takeExc) begin
        newPc         <= handlerAddr;
        newNextPc     <= handlerAddr + STEP;
        newNextNextPc <= handlerAddr + 2 * STEP;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int INSN_BYTES = 4,
  parameter int SS_W = 4,
  parameter int CODE_W = 5,
  parameter int CE_W = 2,
  parameter int VEC_W = 12,
  parameter logic [XLEN-1:0] EBASE_RST = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [VEC_W-1:0]  excVecOfs,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   nextPc,
  input  logic [XLEN-1:0]   nextNextPc,
  input  logic              swWrEn,
  input  logic [2:0]        swWrSel,
  input  logic [XLEN-1:0]   swWrData,
  output logic              statusExl,
  output logic              statusBev,
  output logic [SS_W-1:0]   shadowCss,
  output logic [SS_W-1:0]   shadowEss,
  output logic [SS_W-1:0]   shadowPss,
  output logic [XLEN-1:0]   epc,
  output logic [CODE_W-1:0] causeCode,
  output logic              causeBd,
  output logic [CE_W-1:0]   causeCe,
  output logic [XLEN-1:0]   ebase,
  output logic              redirect,
  output logic [XLEN-1:0]   newPc,
  output logic [XLEN-1:0]   newNextPc,
  output logic [XLEN-1:0]   newNextNextPc
);
  ctlStrobes_t strobes;
  logic        unusedNnpc;

  // The incoming next-next PC is not needed for entry; it is folded away here.
  assign unusedNnpc = ^nextNextPc;

  exc_entry_ctl #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) ctl_i (
    .excReq(excReq), .statusExl(statusExl), .statusBev(statusBev),
    .curPc(curPc), .nextPc(nextPc), .swWrEn(swWrEn), .swWrSel(swWrSel),
    .strobes(strobes)
  );

  exc_entry_dp #(
    .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .SS_W(SS_W), .CODE_W(CODE_W),
    .CE_W(CE_W), .VEC_W(VEC_W), .EBASE_RST(EBASE_RST)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .excCode(excCode),
    .excVecOfs(excVecOfs), .curPc(curPc), .swWrData(swWrData),
    .statusExl(statusExl), .statusBev(statusBev),
    .shadowCss(shadowCss), .shadowEss(shadowEss), .shadowPss(shadowPss),
    .epc(epc), .causeCode(causeCode), .causeBd(causeBd), .causeCe(causeCe),
    .ebase(ebase), .redirect(redirect), .newPc(newPc),
    .newNextPc(newNextPc), .newNextNextPc(newNextNextPc)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32,
  parameter int INSN_BYTES = 4,
  parameter int SS_W = 4,
  parameter int CODE_W = 5,
  parameter int CE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              excReq,
  input logic [CODE_W-1:0] excCode,
  input logic [XLEN-1:0]   curPc,
  input logic [XLEN-1:0]   nextPc,
  input logic              statusExl,
  input logic              statusBev,
  input logic [SS_W-1:0]   shadowCss,
  input logic [SS_W-1:0]   shadowEss,
  input logic [SS_W-1:0]   shadowPss,
  input logic [XLEN-1:0]   epc,
  input logic [CODE_W-1:0] causeCode,
  input logic              causeBd,
  input logic [CE_W-1:0]   causeCe,
  input logic              redirect,
  input logic [XLEN-1:0]   newPc,
  input logic [XLEN-1:0]   newNextPc,
  input logic [XLEN-1:0]   newNextNextPc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  p_exl_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> statusExl);

  p_shadow_swap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !statusExl && !statusBev) |=>
      (shadowPss == $past(shadowCss)) && (shadowCss == $past(shadowEss)));

  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && (statusExl || statusBev)) |=>
      $stable(shadowCss) && $stable(shadowEss) && $stable(shadowPss));

  p_delay_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && (curPc + STEP != nextPc)) |=>
      causeBd && (epc == $past(curPc) - STEP));

  p_straight_r5: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && (curPc + STEP == nextPc)) |=> !causeBd && (epc == $past(curPc)));

  p_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (causeCe == '0) && (causeCode == $past(excCode)));

  p_bev_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> $stable(statusBev));

  p_redirect_r9: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> redirect);

  p_no_redirect_r9: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |=> !redirect && $stable(newPc));

  p_triplet_r9: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (newNextPc == newPc + STEP) && (newNextNextPc == newPc + 2 * STEP));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .SS_W(SS_W), .CODE_W(CODE_W), .CE_W(CE_W)
) chk_i (
  .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode),
  .curPc(curPc), .nextPc(nextPc), .statusExl(statusExl), .statusBev(statusBev),
  .shadowCss(shadowCss), .shadowEss(shadowEss), .shadowPss(shadowPss),
  .epc(epc), .causeCode(causeCode), .causeBd(causeBd), .causeCe(causeCe),
  .redirect(redirect), .newPc(newPc), .newNextPc(newNextPc),
  .newNextNextPc(newNextNextPc)
);

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [4:0]  excCode = '0;
  logic [11:0] excVecOfs = '0;
  logic [31:0] curPc = '0, nextPc = 32'd4, nextNextPc = 32'd8;
  logic        swWrEn = 1'b0;
  logic [2:0]  swWrSel = '0;
  logic [31:0] swWrData = '0;
  logic        statusExl, statusBev, causeBd, redirect;
  logic [3:0]  shadowCss, shadowEss, shadowPss;
  logic [31:0] epc, ebase, newPc, newNextPc, newNextNextPc;
  logic [4:0]  causeCode;
  logic [1:0]  causeCe;

  int total = 0;
  int bad = 0;

  // Bench model of the block state
  logic        mExl, mBev, mBd, mRedir;
  logic [3:0]  mCss, mEss, mPss;
  logic [31:0] mEpc, mEbase, mPc, mNpc, mNnpc;
  logic [4:0]  mCode;
  logic [1:0]  mCe;

  always #2.5 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode),
    .excVecOfs(excVecOfs), .curPc(curPc), .nextPc(nextPc),
    .nextNextPc(nextNextPc), .swWrEn(swWrEn), .swWrSel(swWrSel),
    .swWrData(swWrData), .statusExl(statusExl), .statusBev(statusBev),
    .shadowCss(shadowCss), .shadowEss(shadowEss), .shadowPss(shadowPss),
    .epc(epc), .causeCode(causeCode), .causeBd(causeBd), .causeCe(causeCe),
    .ebase(ebase), .redirect(redirect), .newPc(newPc),
    .newNextPc(newNextPc), .newNextNextPc(newNextNextPc)
  );

  function automatic logic [31:0] handlerOf(logic bev, logic [31:0] base,
                                            logic [11:0] ofs);
    return bev ? 32'hBFC0_0200 : base + {20'd0, ofs};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R2", {31'd0, statusExl}, {31'd0, mExl}, "exl");
    chk("R8", {31'd0, statusBev}, {31'd0, mBev}, "bev");
    chk("R3", {20'd0, shadowPss, shadowEss, shadowCss}, {20'd0, mPss, mEss, mCss}, "shadow");
    chk("R5", epc, mEpc, "epc");
    chk("R5", {31'd0, causeBd}, {31'd0, mBd}, "bd");
    chk("R6", {25'd0, causeCe, causeCode}, {25'd0, mCe, mCode}, "cause");
    chk("R10", ebase, mEbase, "ebase");
    chk("R9", {31'd0, redirect}, {31'd0, mRedir}, "redirect");
    chk("R7", newPc, mPc, "newPc");
    chk("R9", newNextPc, mNpc, "newNextPc");
    chk("R9", newNextNextPc, mNnpc, "newNextNextPc");
  endtask

  task automatic modelReset();
    mExl = 0; mBev = 1; mCss = 0; mEss = 0; mPss = 0; mEpc = 0; mCode = 0;
    mBd = 0; mCe = 0; mEbase = 32'h8000_0000; mRedir = 0;
    mPc = 32'hBFC0_0000; mNpc = 32'hBFC0_0004; mNnpc = 32'hBFC0_0008;
  endtask

  // Drives one cycle of stimulus, advances the model, checks after the edge.
  task automatic step(logic req, logic [4:0] code, logic [11:0] ofs,
                      logic [31:0] pc, logic [31:0] npc,
                      logic we, logic [2:0] sel, logic [31:0] data);
    logic [31:0] h;
    excReq = req; excCode = code; excVecOfs = ofs; curPc = pc; nextPc = npc;
    nextNextPc = npc + 4; swWrEn = we; swWrSel = sel; swWrData = data;
    if (req) begin
      h = handlerOf(mBev, mEbase, ofs);
      if (!mExl && !mBev) begin mPss = mCss; mCss = mEss; end
      mExl = 1;
      mBd = (pc + 4 != npc);
      mEpc = mBd ? pc - 4 : pc;
      mCode = code; mCe = 0;
      mRedir = 1; mPc = h; mNpc = h + 4; mNnpc = h + 8;
    end else begin
      mRedir = 0;
      if (we) begin
        case (sel)
          3'd0: begin mExl = data[0]; mBev = data[1]; end
          3'd1: begin mCss = data[3:0]; mEss = data[7:4]; mPss = data[11:8]; end
          3'd2: mEpc = data;
          3'd3: begin mCode = data[4:0]; mBd = data[5]; mCe = data[7:6]; end
          3'd4: mEbase = data;
          default: ;
        endcase
      end
    end
    @(posedge clk); #1;
    checkAll();
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    chk("R1", {31'd0, statusBev}, 32'd1, "bev after reset");
    chk("R1", {31'd0, statusExl}, 32'd0, "exl after reset");
    chk("R1", newPc, 32'hBFC0_0000, "reset vector");
    chk("R1", {20'd0, shadowPss, shadowEss, shadowCss}, 32'd0, "shadow after reset");
    chk("R1", {31'd0, redirect}, 32'd0, "redirect after reset");

    // R8: entry with boot vector set goes to the fixed handler, no swap (R4)
    step(1'b0, 5'd0, 12'd0, 0, 4, 1'b1, 3'd1, 32'h0000_0321);
    step(1'b1, 5'hC, 12'h180, 32'h1000, 32'h1004, 1'b0, 3'd0, 0);
    chk("R8", newPc, 32'hBFC0_0200, "boot handler");
    chk("R4", {28'd0, shadowCss}, 32'h1, "css held with bev=1");

    // R10: clear status, load base; R7 + R3: overflow entry from user level
    step(1'b0, 5'd0, 12'd0, 0, 4, 1'b1, 3'd0, 32'h0);
    step(1'b0, 5'd0, 12'd0, 0, 4, 1'b1, 3'd4, 32'h8000_1000);
    step(1'b1, 5'hC, 12'h180, 32'h2000, 32'h2004, 1'b0, 3'd0, 0);
    chk("R7", newPc, 32'h8000_1180, "ebase handler");
    chk("R3", {28'd0, shadowCss}, 32'h2, "css took ess");
    chk("R3", {28'd0, shadowPss}, 32'h1, "pss took css");
    chk("R2", {31'd0, statusExl}, 32'd1, "exl set");

    // R4 + R2: nested entry with exl already 1, in a delay slot (R5)
    step(1'b1, 5'h4, 12'h180, 32'h3000, 32'h5000, 1'b0, 3'd0, 0);
    chk("R5", epc, 32'h2FFC, "rewound epc");
    chk("R5", {31'd0, causeBd}, 32'd1, "bd set");
    chk("R4", {28'd0, shadowPss}, 32'h1, "pss held with exl=1");

    // R10: write colliding with entry is dropped; R9 strobe lasts one cycle
    step(1'b1, 5'h1F, 12'h200, 32'h4000, 32'h4004, 1'b1, 3'd4, 32'h1234_5678);
    chk("R10", ebase, 32'h8000_1000, "colliding write dropped");
    step(1'b0, 5'd0, 12'd0, 0, 4, 1'b0, 3'd0, 0);
    chk("R9", {31'd0, redirect}, 32'd0, "strobe one cycle");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] pc = {$urandom, 2'b00} & 32'h0FFF_FFFC;
      logic [31:0] npc = ($urandom % 3 == 0) ? ({$urandom} & 32'h0FFF_FFFC) : pc + 4;
      logic [2:0] sel = 3'($urandom % 5);
      logic [31:0] d = $urandom;
      if (sel == 3'd0) d[1] = ($urandom % 2 == 0) ? 1'b0 : d[1];
      step(($urandom % 3) == 0, 5'($urandom), ($urandom % 2) ? 12'h180 : 12'($urandom),
           pc, npc, ($urandom % 2) == 0, sel, d);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule